// File: doc/BRIEF.md
# Event-Counting Performance Monitor

This block counts processor activity for profiling. It holds one free-running cycle counter and four programmable event counters, all 32 bits wide. Each event counter watches one line of a 32-line vector of single-cycle event pulses, chosen by an 8-bit code. Software reaches the block through a plain register bus. The bus has an address, a write strobe, write data, and a read path that returns data in the same cycle.

Software preloads a counter with a start value so that it wraps after a chosen number of events. A wrap from all-ones to zero sets a sticky overflow flag. If the matching interrupt enable bit is set, that flag raises a level interrupt. The cycle counter can be slowed down so that it advances once every 64 clocks, which stretches its range. Control bits start and stop all counting together and clear either counter group.

Top module: `perf_monitor`

## Requirements
- R1: After reset the control, flag, enable and counter registers read 0. The event-select register reads 0xFFFFFFFF, so every counter is parked on the unused code. The interrupt output is low.
- R2: The control register is at address 0. On write, only bit 0 (run), bit 1 (clear event counters), bit 2 (clear cycle counter) and bit 3 (divide-by-64) are taken. All upper bits are dropped. Bits 1 and 2 always read back as 0.
- R3: Event counters are read and written at addresses 5 to 8, for counters 0 to 3. An event counter adds one in each clock where run is 1 and the event line selected by its code is high. A code of 32 or more, including 0xFF, never counts. When run is 0, no counter changes except through a bus write.
- R4: The event-select register is at address 3. Counter 0 takes its code from bits 7:0, counter 1 from bits 15:8, counter 2 from bits 23:16 and counter 3 from bits 31:24.
- R5: The cycle counter is read and written at address 4. With run set, it adds one every clock when bit 3 is 0. When bit 3 is 1, it adds one every 64th clock. The divider phase restarts when the cycle counter is cleared.
- R6: A control write with bit 1 set makes all four event counters read 0 on the next cycle. A control write with bit 2 set does the same for the cycle counter. Each of these bits leaves the other counter group untouched, and the clear takes priority over any increment in that cycle.
- R7: A bus write to any counter preloads it. When the write falls in the same cycle as an increment of that counter, the written value is kept.
- R8: When a counter steps from 0xFFFFFFFF to 0, its overflow flag sets. The flag register is at address 1. Bit 0 belongs to the cycle counter and bits 1 to 4 to event counters 0 to 3.
- R9: Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged. If an overflow and a clear of the same flag fall in the same cycle, the flag stays set.
- R10: The interrupt enable register is at address 2 and uses the same bit positions as the flags. The interrupt output is a register loaded with the OR of the flags ANDed with the enables. It therefore follows them one cycle late and stays high until software clears the flags or the enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address, same cycle |
| evt_in | input | 32 | Event pulses, line n carries the event with code n |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of functions can land in the same cycle. A counter increment can meet a software preload of that counter, and an overflow can meet a write-one-to-clear of the same flag. The bench provokes both on purpose. It writes a counter while that counter's event line is pulsing. It also pulses the event that wraps a preloaded counter in the very cycle the flag-clear write happens. A long random phase then mixes preloads near the wrap point with event traffic so that both cases recur. Each time the written value must be kept and the flag must stay set, and a behavioural model compares every register read and the interrupt on every clock.

// File: rtl/perf_monitor_pkg.sv
`timescale 1ns/1ps
package perf_monitor_pkg;
    // register addresses
    localparam int ADR_CTRL     = 0;
    localparam int ADR_FLAGS    = 1;
    localparam int ADR_IRQEN    = 2;
    localparam int ADR_EVSEL    = 3;
    localparam int ADR_CNT_BASE = 4;   // cycle counter, then event counters

    // control bit positions
    localparam int CTRL_RUN     = 0;
    localparam int CTRL_CLR_EVT = 1;
    localparam int CTRL_CLR_CYC = 2;
    localparam int CTRL_DIV     = 3;
endpackage

// File: rtl/pmon_event_pick.sv
`timescale 1ns/1ps
module pmon_event_pick #(
    parameter int CODE_W = 8,
    parameter int NUM_IN = 32
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [NUM_IN-1:0] evt_i,
    output logic              hit_o
);
    // codes at or above NUM_IN match no line and never count
    always_comb begin
        hit_o = 1'b0;
        for (int j = 0; j < NUM_IN; j++) begin
            if (code_i == CODE_W'(j)) hit_o = evt_i[j];
        end
    end
endmodule

// File: rtl/pmon_counter.sv
`timescale 1ns/1ps
module pmon_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] value_o,
    output logic         wrap_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    // priority: bus write, then clear, then increment
    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        if (wr_i) begin
            st_d.cnt = wdata_i;
        end else if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + W'(1);
            wrap_o   = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value_o = st_q.cnt;

    // R7: a preload is what the counter holds afterwards
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (value_o == $past(wdata_i)));

    // R6: a clear without a write leaves zero
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !wr_i) |=> (value_o == '0));
endmodule

// File: rtl/pmon_regs.sv
`timescale 1ns/1ps
module pmon_regs
    import perf_monitor_pkg::*;
#(
    parameter int NUM_CTR  = 5,
    parameter int EVSEL_W  = 32,
    parameter int PRESCALE = 64,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_CTR-1:0] wrap_i,
    output logic               run_o,
    output logic               clr_evt_o,
    output logic               clr_cyc_o,
    output logic               cyc_tick_o,
    output logic [EVSEL_W-1:0] evsel_o,
    output logic [NUM_CTR-1:0] flags_o,
    output logic [NUM_CTR-1:0] irqen_o,
    output logic [DATA_W-1:0]  ctrl_rd_o,
    output logic               irq_o
);
    localparam int PRE_W = $clog2(PRESCALE);

    typedef struct packed {
        logic               run;
        logic               div;
        logic [PRE_W-1:0]   pre;
        logic [NUM_CTR-1:0] flags;
        logic [NUM_CTR-1:0] irqen;
        logic [EVSEL_W-1:0] evsel;
        logic               irq;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic wr_ctrl, wr_flags, wr_irqen, wr_evsel;

    assign wr_ctrl  = wr_i && (addr_i == ADDR_W'(ADR_CTRL));
    assign wr_flags = wr_i && (addr_i == ADDR_W'(ADR_FLAGS));
    assign wr_irqen = wr_i && (addr_i == ADDR_W'(ADR_IRQEN));
    assign wr_evsel = wr_i && (addr_i == ADDR_W'(ADR_EVSEL));

    assign clr_evt_o = wr_ctrl && wdata_i[CTRL_CLR_EVT];
    assign clr_cyc_o = wr_ctrl && wdata_i[CTRL_CLR_CYC];

    always_comb begin
        st_d       = st_q;
        cyc_tick_o = st_q.run && (!st_q.div || (st_q.pre == PRE_W'(PRESCALE - 1)));

        if (st_q.run && st_q.div) st_d.pre = st_q.pre + PRE_W'(1);

        if (wr_ctrl) begin
            st_d.run = wdata_i[CTRL_RUN];
            st_d.div = wdata_i[CTRL_DIV];
            if (wdata_i[CTRL_CLR_CYC]) st_d.pre = '0;
        end
        if (wr_irqen) st_d.irqen = wdata_i[NUM_CTR-1:0];
        if (wr_evsel) st_d.evsel = wdata_i[EVSEL_W-1:0];

        // clear-on-one first, new overflows on top so a set wins
        st_d.flags = (st_q.flags & ~(wr_flags ? wdata_i[NUM_CTR-1:0] : '0)) | wrap_i;

        st_d.irq = |(st_q.flags & st_q.irqen);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.evsel <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_rd_o           = '0;
        ctrl_rd_o[CTRL_RUN] = st_q.run;
        ctrl_rd_o[CTRL_DIV] = st_q.div;
    end

    assign run_o   = st_q.run;
    assign evsel_o = st_q.evsel;
    assign flags_o = st_q.flags;
    assign irqen_o = st_q.irqen;
    assign irq_o   = st_q.irq;

    // R8: every wrap reported by a counter appears in the flags
    assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap_i) |=> ((st_q.flags & $past(wrap_i)) == $past(wrap_i)));

    // R9: a cleared flag with no coincident wrap reads zero
    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flags |=> ((st_q.flags & $past(wdata_i[NUM_CTR-1:0] & ~wrap_i)) == '0));

    // R10: the request only follows an enabled flag of the cycle before
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(|(st_q.flags & st_q.irqen)));
endmodule

// File: rtl/perf_monitor.sv
`timescale 1ns/1ps
module perf_monitor
    import perf_monitor_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int NUM_EVT_CTR = 4,
    parameter int CODE_W      = 8,
    parameter int NUM_EVT_IN  = 32,
    parameter int PRESCALE    = 64,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_EVT_IN-1:0] evt_in,
    output logic                  irq
);
    localparam int NUM_CTR = NUM_EVT_CTR + 1;
    localparam int EVSEL_W = NUM_EVT_CTR * CODE_W;

    logic                           run, clr_evt, clr_cyc, cyc_tick;
    logic [EVSEL_W-1:0]             evsel;
    logic [NUM_CTR-1:0]             flags, irqen, wrap, wr_cnt;
    logic [DATA_W-1:0]              ctrl_rd;
    logic [NUM_CTR-1:0][CNT_W-1:0]  cnt_val;

    pmon_regs #(
        .NUM_CTR (NUM_CTR),
        .EVSEL_W (EVSEL_W),
        .PRESCALE(PRESCALE),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .wrap_i    (wrap),
        .run_o     (run),
        .clr_evt_o (clr_evt),
        .clr_cyc_o (clr_cyc),
        .cyc_tick_o(cyc_tick),
        .evsel_o   (evsel),
        .flags_o   (flags),
        .irqen_o   (irqen),
        .ctrl_rd_o (ctrl_rd),
        .irq_o     (irq)
    );

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_wdec
        assign wr_cnt[k] = reg_wr && (reg_addr == ADDR_W'(ADR_CNT_BASE + k));
    end

    pmon_counter #(.W(CNT_W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (cyc_tick),
        .clr_i  (clr_cyc),
        .wr_i   (wr_cnt[0]),
        .wdata_i(reg_wdata[CNT_W-1:0]),
        .value_o(cnt_val[0]),
        .wrap_o (wrap[0])
    );

    for (genvar g = 0; g < NUM_EVT_CTR; g++) begin : g_evt
        logic hit;

        pmon_event_pick #(.CODE_W(CODE_W), .NUM_IN(NUM_EVT_IN)) u_pick (
            .code_i(evsel[g*CODE_W +: CODE_W]),
            .evt_i (evt_in),
            .hit_o (hit)
        );

        pmon_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc_i  (run && hit),
            .clr_i  (clr_evt),
            .wr_i   (wr_cnt[g+1]),
            .wdata_i(reg_wdata[CNT_W-1:0]),
            .value_o(cnt_val[g+1]),
            .wrap_o (wrap[g+1])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADR_CTRL))  reg_rdata = ctrl_rd;
        if (reg_addr == ADDR_W'(ADR_FLAGS)) reg_rdata = DATA_W'(flags);
        if (reg_addr == ADDR_W'(ADR_IRQEN)) reg_rdata = DATA_W'(irqen);
        if (reg_addr == ADDR_W'(ADR_EVSEL)) reg_rdata = DATA_W'(evsel);
        for (int k = 0; k < NUM_CTR; k++) begin
            if (reg_addr == ADDR_W'(ADR_CNT_BASE + k)) reg_rdata = DATA_W'(cnt_val[k]);
        end
    end

    // R3: with counting stopped and no bus write, every counter holds
    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reg_wr) |=> $stable(cnt_val));
endmodule

// File: tb/perf_monitor_test.sv
`timescale 1ns/1ps
module perf_monitor_test;
    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr  = '0;
    logic        wr    = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] evt   = '0;
    logic [31:0] rdata;
    logic        irq;

    always #10 clk = ~clk;   // 50 MHz

    perf_monitor uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (addr),
        .reg_wr   (wr),
        .reg_wdata(wdata),
        .reg_rdata(rdata),
        .evt_in   (evt),
        .irq      (irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural model state
    logic        m_run, m_div;
    int          m_pre;
    logic [31:0] m_cnt [5];
    logic [4:0]  m_flags, m_ie;
    logic [31:0] m_evsel;
    logic        m_irq;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        if (a == 4'd0) return {28'd0, m_div, 2'b00, m_run};
        if (a == 4'd1) return {27'd0, m_flags};
        if (a == 4'd2) return {27'd0, m_ie};
        if (a == 4'd3) return m_evsel;
        if (a >= 4'd4 && a <= 4'd8) return m_cnt[int'(a) - 4];
        return 32'd0;
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        if (a == 4'd0) return "R2";
        if (a == 4'd1) return "R9";
        if (a == 4'd2) return "R10";
        if (a == 4'd3) return "R4";
        if (a == 4'd4) return "R5";
        return "R3";
    endfunction

    always @(posedge clk) begin : model
        logic [4:0]  inc, wrapv, nflags;
        logic [31:0] ncnt [5];
        logic [7:0]  code;
        int          idx;
        if (!rst_n) begin
            m_run = 0; m_div = 0; m_pre = 0; m_flags = 0; m_ie = 0;
            m_evsel = 32'hFFFF_FFFF; m_irq = 0;
            for (int k = 0; k < 5; k++) m_cnt[k] = 0;
        end else begin
            inc[0] = m_run && (!m_div || m_pre == 63);
            for (int i = 0; i < 4; i++) begin
                code     = m_evsel[8*i +: 8];
                inc[i+1] = m_run && (code < 8'd32) && evt[code[4:0]];
            end
            for (int k = 0; k < 5; k++) begin
                ncnt[k]  = m_cnt[k];
                wrapv[k] = 1'b0;
                if (inc[k]) begin
                    wrapv[k] = (m_cnt[k] == 32'hFFFF_FFFF);
                    ncnt[k]  = m_cnt[k] + 32'd1;
                end
            end
            if (wr && addr == 4'd0) begin
                if (wdata[2]) begin ncnt[0] = 0; wrapv[0] = 0; end
                if (wdata[1]) for (int k = 1; k < 5; k++) begin ncnt[k] = 0; wrapv[k] = 0; end
            end
            if (wr && addr >= 4'd4 && addr <= 4'd8) begin
                idx = int'(addr) - 4;
                ncnt[idx]  = wdata;
                wrapv[idx] = 1'b0;
            end
            nflags = m_flags;
            if (wr && addr == 4'd1) nflags = nflags & ~wdata[4:0];
            nflags = nflags | wrapv;
            m_irq  = |(m_flags & m_ie);
            if (m_run && m_div) m_pre = (m_pre + 1) % 64;
            if (wr && addr == 4'd0) begin
                if (wdata[2]) m_pre = 0;
                m_run = wdata[0];
                m_div = wdata[3];
            end
            if (wr && addr == 4'd2) m_ie = wdata[4:0];
            if (wr && addr == 4'd3) m_evsel = wdata;
            m_flags = nflags;
            for (int k = 0; k < 5; k++) m_cnt[k] = ncnt[k];
        end
        #5;
        if (rst_n && !done) begin
            check(tag_of(addr), rdata, model_read(addr));
            check("R10", {31'd0, irq}, {31'd0, m_irq});
        end
    end

    task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d, input logic [31:0] e);
        wr = w; addr = a; wdata = d; evt = e;
        @(negedge clk);
    endtask

    task automatic expect_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
        wr = 1'b0; evt = '0; addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg("R1", 4'd0, 32'd0);
        expect_reg("R1", 4'd1, 32'd0);
        expect_reg("R1", 4'd2, 32'd0);
        expect_reg("R1", 4'd3, 32'hFFFF_FFFF);
        for (int k = 4; k <= 8; k++) expect_reg("R1", 4'(k), 32'd0);
        check("R1", {31'd0, irq}, 32'd0);

        // R2 control write masking
        step(1, 4'd0, 32'hFFFF_FFF9, 0);
        expect_reg("R2", 4'd0, 32'h9);

        // R4 field positions: c0=0x00 c1=0x05 c2=0x07 c3=0x0B
        step(1, 4'd3, 32'h0B07_0500, 0);
        expect_reg("R4", 4'd3, 32'h0B07_0500);
        step(1, 4'd0, 32'h1, 0);
        step(1, 4'd6, 32'd0, 0);
        repeat (3) step(0, 4'd0, 0, 32'h20);
        expect_reg("R4", 4'd6, 32'd3);

        // R3 unused codes (0xFF and 0x40) never count
        step(1, 4'd3, 32'h0B07_40FF, 0);
        step(1, 4'd5, 32'h55, 0);
        step(1, 4'd6, 32'h66, 0);
        repeat (4) step(0, 4'd0, 0, 32'hFFFF_FFFF);
        expect_reg("R3", 4'd5, 32'h55);
        expect_reg("R3", 4'd6, 32'h66);

        // R3 stopped counters hold
        step(1, 4'd0, 32'd0, 0);
        step(1, 4'd7, 32'h10, 0);
        repeat (5) step(0, 4'd0, 0, 32'hFFFF_FFFF);
        expect_reg("R3", 4'd7, 32'h10);

        // R6 event-group clear leaves the cycle counter alone
        step(1, 4'd4, 32'h777, 0);
        step(1, 4'd0, 32'h3, 32'hFFFF_FFFF);
        for (int k = 5; k <= 8; k++) expect_reg("R6", 4'(k), 32'd0);
        expect_reg("R6", 4'd4, 32'h777);

        // R5 cycle counting, full rate then divided
        step(1, 4'd0, 32'h5, 0);
        repeat (10) step(0, 4'd0, 0, 0);
        expect_reg("R5", 4'd4, 32'd10);
        step(1, 4'd0, 32'hD, 0);
        repeat (63) step(0, 4'd0, 0, 0);
        expect_reg("R5", 4'd4, 32'd0);
        step(0, 4'd0, 0, 0);
        expect_reg("R5", 4'd4, 32'd1);

        step(1, 4'd0, 32'h1, 0);
        step(1, 4'd3, 32'h0B07_0500, 0);

        // R7 write beats a coincident increment
        step(1, 4'd7, 32'h1234, 32'h80);
        expect_reg("R7", 4'd7, 32'h1234);

        // R8 / R10 overflow of event counter 2
        step(1, 4'd2, 32'h08, 0);
        step(1, 4'd7, 32'hFFFF_FFFE, 0);
        step(0, 4'd0, 0, 32'h80);
        expect_reg("R8", 4'd7, 32'hFFFF_FFFF);
        step(0, 4'd0, 0, 32'h80);
        expect_reg("R8", 4'd7, 32'd0);
        expect_reg("R8", 4'd1, 32'h08);
        check("R10", {31'd0, irq}, 32'd0);
        step(0, 4'd1, 0, 0);
        check("R10", {31'd0, irq}, 32'd1);

        // R9 write-one-to-clear
        step(1, 4'd1, 32'd0, 0);
        expect_reg("R9", 4'd1, 32'h08);
        step(1, 4'd1, 32'h08, 0);
        expect_reg("R9", 4'd1, 32'd0);
        check("R10", {31'd0, irq}, 32'd1);
        step(0, 4'd1, 0, 0);
        check("R10", {31'd0, irq}, 32'd0);

        // R9 set wins over coincident clear (counter 3, code 0x0B)
        step(1, 4'd8, 32'hFFFF_FFFF, 0);
        step(1, 4'd1, 32'h10, 32'h800);
        expect_reg("R9", 4'd1, 32'h10);

        // R8 cycle counter wrap
        step(1, 4'd4, 32'hFFFF_FFF0, 0);
        repeat (16) step(0, 4'd0, 0, 0);
        expect_reg("R8", 4'd4, 32'd0);
        expect_reg("R8", 4'd1, 32'h11);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  a;
            logic [31:0] d;
            a = 4'($urandom_range(0, 8));
            d = $urandom;
            if (a >= 4'd4 && $urandom_range(0, 1) == 1) d = 32'hFFFF_FFF0 | (d & 32'hF);
            if (a == 4'd0) d[0] = ($urandom_range(0, 3) != 0);
            if (a == 4'd3 && $urandom_range(0, 1) == 1) d = d & 32'h1F1F_1F1F;
            step($urandom_range(0, 7) == 0, a, d, $urandom);
        end

        done = 1'b1;
        finish_run();
    end
endmodule